// File: doc/BRIEF.md
# Four-Way Multiply Add-Subtract Sum

This block is a pipelined arithmetic slice. It holds four multipliers. Each one multiplies an `A_W`-bit operand A by a `B_W`-bit operand B. Products 0 and 1 feed the first adder/subtractor, and products 2 and 3 feed the second. Each of the two adder/subtractors has its own run-time direction bit. Their two results are added into one output that is `A_W+B_W+2` bits wide. One mode bit chooses between two's-complement and unsigned arithmetic for the whole datapath. A caller with narrower operands widens them before they reach the ports: sign-extension in signed mode, zero-fill in unsigned mode.

The slice has three register stages: input, post-multiply pipeline and output. A parameter can bypass each stage, so the latency equals the number of stages that are kept. Each stage takes its clock enable from one of four shared enable inputs and its synchronous reset from one of four shared reset inputs. These choices are static and are made separately for each stage. The four A input registers can be linked into a shift chain, with a serial input and a serial output. The four B input registers form a second chain of the same kind. This lets operands stream from one slice into the next.

Top module: `mpas_quad_sum`

## Requirements
- R1: The sum for a set of operands appears on `sum_out` after as many rising edges as there are enabled register stages. With the default build, that is three edges.
- R2: With `signed_mode`=0, operands are unsigned and `sum_out` equals (A0·B0 ± A1·B1) + (A2·B2 ± A3·B3) modulo 2^(A_W+B_W+2).
- R3: With `signed_mode`=1, operands are two's complement and `sum_out` equals the same expression, evaluated as signed values, modulo 2^(A_W+B_W+2).
- R4: `pair0_add`=1 adds product 1 to product 0, and 0 subtracts product 1 from product 0. `pair1_add` does the same for products 2 and 3. Both bits, and `signed_mode`, travel through the input and pipeline stages together with the operands they apply to.
- R5: When the input stage captures with `a_shift`=1, lane 0 of A loads `a_shift_in` and lane i loads lane i−1. `a_shift_out` always shows lane 3 of A.
- R6: When the input stage captures with `b_shift`=1, the B lanes shift in the same way from `b_shift_in`. `b_shift_out` always shows lane 3 of B.
- R7: While the enable selected for a stage is low, and its reset is low, that stage keeps its contents.
- R8: A high level on the reset selected for a stage clears every register of that stage at the next rising edge. Reset wins over enable.
- R9: Each stage responds only to the enable index and reset index chosen for it. Enable and reset inputs that no stage selects have no effect on any output.
- R10: With all three stages bypassed, `sum_out` and the shift outputs are combinational functions of the current inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all stages |
| ce | input | 4 | Four shared clock-enable sources |
| rst | input | 4 | Four shared synchronous reset sources, active high |
| signed_mode | input | 1 | 1 = two's-complement arithmetic, 0 = unsigned |
| pair0_add | input | 1 | 1 = P0+P1, 0 = P0−P1 |
| pair1_add | input | 1 | 1 = P2+P3, 0 = P2−P3 |
| a_in | input | 4*A_W | Parallel A operands, lane i in bits [i*A_W +: A_W] |
| b_in | input | 4*B_W | Parallel B operands, lane i in bits [i*B_W +: B_W] |
| a_shift | input | 1 | A lanes load from the chain instead of `a_in` |
| b_shift | input | 1 | B lanes load from the chain instead of `b_in` |
| a_shift_in | input | A_W | Serial input of the A chain |
| b_shift_in | input | B_W | Serial input of the B chain |
| a_shift_out | output | A_W | A lane 3 value, to a following slice |
| b_shift_out | output | B_W | B lane 3 value, to a following slice |
| sum_out | output | A_W+B_W+2 | Final sum |

## Verification
In the registered build, `sum_out` reflects an operand set three rising edges after it is presented, and the shift outputs reflect it one edge later. When a stage enable is held low, that stage's part of the delay grows by the number of held cycles. The bench drives inputs just after each rising edge. It advances a behavioural model at the same edge, and compares every output at the falling edge, so each result is read in the cycle it is due. A second instance with every stage bypassed is compared in the same cycle, against a value computed from the inputs that are applied.

// File: rtl/mpas_pkg.sv
package mpas_pkg;
   localparam int LANES = 4;
   localparam int NSRC  = 4;

   // Controls that ride alongside the operands through the stages
   typedef struct packed {
      logic sgn;
      logic add1;
      logic add0;
   } ctrl_t;

   // Extension bit for a sum or difference that is one bit wider than its terms
   function automatic logic pair_ext(input logic msb, input logic sgn, input logic add);
      return msb & (sgn | ~add);
   endfunction
endpackage

// File: rtl/mpas_stage_reg.sv
module mpas_stage_reg #(
   parameter int W  = 8,
   parameter bit EN = 1'b1
) (
   input  logic         clk,
   input  logic         ce,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad_w
         $error("mpas_stage_reg: W must be at least 1");
      end
      if (EN) begin : g_reg
         logic [W-1:0] r;
         always_ff @(posedge clk) begin
            if (rst)     r <= '0;
            else if (ce) r <= d;
         end
         assign q = r;
      end else begin : g_wire
         logic unused_ctl;
         assign unused_ctl = ^{clk, ce, rst};
         assign q = d;
      end
   endgenerate
endmodule

// File: rtl/mpas_operand_chain.sv
module mpas_operand_chain #(
   parameter int W  = 9,
   parameter int NL = 4,
   parameter bit EN = 1'b1
) (
   input  logic          clk,
   input  logic          ce,
   input  logic          rst,
   input  logic          shift,
   input  logic [W-1:0]  ser_in,
   input  logic [NL*W-1:0] par_in,
   output logic [NL*W-1:0] q,
   output logic [W-1:0]  ser_out
);
   generate
      if (NL < 1) begin : g_bad_nl
         $error("mpas_operand_chain: NL must be at least 1");
      end
      for (genvar i = 0; i < NL; i++) begin : g_lane
         logic [W-1:0] prev;
         logic [W-1:0] d;
         if (i == 0) begin : g_head
            assign prev = ser_in;
         end else begin : g_link
            assign prev = q[(i-1)*W +: W];
         end
         assign d = shift ? prev : par_in[i*W +: W];
         mpas_stage_reg #(.W(W), .EN(EN)) u_reg (
            .clk(clk), .ce(ce), .rst(rst), .d(d), .q(q[i*W +: W])
         );
      end
   endgenerate

   assign ser_out = q[(NL-1)*W +: W];
endmodule

// File: rtl/mpas_mult.sv
module mpas_mult #(
   parameter int A_W = 9,
   parameter int B_W = 9
) (
   input  logic [A_W-1:0]     a,
   input  logic [B_W-1:0]     b,
   input  logic               sgn,
   output logic [A_W+B_W-1:0] p
);
   localparam int PW = A_W + B_W;

   logic [PW-1:0] ax;
   logic [PW-1:0] bx;

   // Widen to the product width; the low PW bits of the product are exact
   assign ax = {{(PW-A_W){sgn & a[A_W-1]}}, a};
   assign bx = {{(PW-B_W){sgn & b[B_W-1]}}, b};
   assign p  = ax * bx;
endmodule

// File: rtl/mpas_addsub.sv
module mpas_addsub #(
   parameter int W = 18
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         sgn,
   input  logic         add,
   output logic [W:0]   r
);
   logic [W:0] xe;
   logic [W:0] ye;

   assign xe = {sgn & x[W-1], x};
   assign ye = {sgn & y[W-1], y};
   assign r  = add ? (xe + ye) : (xe - ye);
endmodule

// File: rtl/mpas_quad_sum.sv
module mpas_quad_sum
   import mpas_pkg::*;
#(
   parameter int A_W          = 9,
   parameter int B_W          = 9,
   parameter bit IN_REG       = 1'b1,
   parameter bit PIPE_REG     = 1'b1,
   parameter bit OUT_REG      = 1'b1,
   parameter int IN_CE_SEL    = 0,
   parameter int IN_RST_SEL   = 0,
   parameter int PIPE_CE_SEL  = 0,
   parameter int PIPE_RST_SEL = 0,
   parameter int OUT_CE_SEL   = 0,
   parameter int OUT_RST_SEL  = 0
) (
   input  logic                   clk,
   input  logic [3:0]             ce,
   input  logic [3:0]             rst,
   input  logic                   signed_mode,
   input  logic                   pair0_add,
   input  logic                   pair1_add,
   input  logic [4*A_W-1:0]       a_in,
   input  logic [4*B_W-1:0]       b_in,
   input  logic                   a_shift,
   input  logic                   b_shift,
   input  logic [A_W-1:0]         a_shift_in,
   input  logic [B_W-1:0]         b_shift_in,
   output logic [A_W-1:0]         a_shift_out,
   output logic [B_W-1:0]         b_shift_out,
   output logic [A_W+B_W+1:0]     sum_out
);
   localparam int PW    = A_W + B_W;
   localparam int RW    = PW + 1;
   localparam int SW    = PW + 2;
   localparam int NPAIR = LANES / 2;

   // ---------------- elaboration checks ----------------
   generate
      if (A_W < 2 || B_W < 2) begin : g_bad_width
         $error("mpas_quad_sum: operand widths must be at least 2");
      end
      if (IN_CE_SEL < 0 || IN_CE_SEL >= NSRC || IN_RST_SEL < 0 || IN_RST_SEL >= NSRC) begin : g_bad_in_sel
         $error("mpas_quad_sum: input stage source index out of range");
      end
      if (PIPE_CE_SEL < 0 || PIPE_CE_SEL >= NSRC || PIPE_RST_SEL < 0 || PIPE_RST_SEL >= NSRC) begin : g_bad_pipe_sel
         $error("mpas_quad_sum: pipeline stage source index out of range");
      end
      if (OUT_CE_SEL < 0 || OUT_CE_SEL >= NSRC || OUT_RST_SEL < 0 || OUT_RST_SEL >= NSRC) begin : g_bad_out_sel
         $error("mpas_quad_sum: output stage source index out of range");
      end
   endgenerate

   // ---------------- per-stage source selection ----------------
   logic ce_in, rst_in, ce_pipe, rst_pipe, ce_out, rst_out;
   assign ce_in    = ce[IN_CE_SEL];
   assign rst_in   = rst[IN_RST_SEL];
   assign ce_pipe  = ce[PIPE_CE_SEL];
   assign rst_pipe = rst[PIPE_RST_SEL];
   assign ce_out   = ce[OUT_CE_SEL];
   assign rst_out  = rst[OUT_RST_SEL];

   // ---------------- input stage ----------------
   logic [LANES*A_W-1:0] a_q;
   logic [LANES*B_W-1:0] b_q;
   ctrl_t ctrl_d, ctrl_i, ctrl_p;

   assign ctrl_d = '{sgn: signed_mode, add1: pair1_add, add0: pair0_add};

   mpas_operand_chain #(.W(A_W), .NL(LANES), .EN(IN_REG)) u_a_chain (
      .clk(clk), .ce(ce_in), .rst(rst_in), .shift(a_shift),
      .ser_in(a_shift_in), .par_in(a_in), .q(a_q), .ser_out(a_shift_out)
   );

   mpas_operand_chain #(.W(B_W), .NL(LANES), .EN(IN_REG)) u_b_chain (
      .clk(clk), .ce(ce_in), .rst(rst_in), .shift(b_shift),
      .ser_in(b_shift_in), .par_in(b_in), .q(b_q), .ser_out(b_shift_out)
   );

   mpas_stage_reg #(.W($bits(ctrl_t)), .EN(IN_REG)) u_ctrl_in (
      .clk(clk), .ce(ce_in), .rst(rst_in), .d(ctrl_d), .q(ctrl_i)
   );

   // ---------------- multipliers and pipeline stage ----------------
   logic [PW-1:0] prod   [LANES];
   logic [PW-1:0] prod_q [LANES];

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         mpas_mult #(.A_W(A_W), .B_W(B_W)) u_mul (
            .a(a_q[i*A_W +: A_W]), .b(b_q[i*B_W +: B_W]),
            .sgn(ctrl_i.sgn), .p(prod[i])
         );
         mpas_stage_reg #(.W(PW), .EN(PIPE_REG)) u_pipe (
            .clk(clk), .ce(ce_pipe), .rst(rst_pipe), .d(prod[i]), .q(prod_q[i])
         );
      end
   endgenerate

   mpas_stage_reg #(.W($bits(ctrl_t)), .EN(PIPE_REG)) u_ctrl_pipe (
      .clk(clk), .ce(ce_pipe), .rst(rst_pipe), .d(ctrl_i), .q(ctrl_p)
   );

   // ---------------- pair adder/subtractors ----------------
   logic [NPAIR-1:0] add_p;
   logic [RW-1:0]    pair_r   [NPAIR];
   logic [NPAIR-1:0] pair_top;

   assign add_p = {ctrl_p.add1, ctrl_p.add0};

   generate
      for (genvar j = 0; j < NPAIR; j++) begin : g_pair
         mpas_addsub #(.W(PW)) u_as (
            .x(prod_q[2*j]), .y(prod_q[2*j+1]),
            .sgn(ctrl_p.sgn), .add(add_p[j]), .r(pair_r[j])
         );
         assign pair_top[j] = pair_ext(pair_r[j][RW-1], ctrl_p.sgn, add_p[j]);
      end
   endgenerate

   // ---------------- final sum and output stage ----------------
   logic [SW-1:0] total;
   assign total = {pair_top[0], pair_r[0]} + {pair_top[1], pair_r[1]};

   mpas_stage_reg #(.W(SW), .EN(OUT_REG)) u_out (
      .clk(clk), .ce(ce_out), .rst(rst_out), .d(total), .q(sum_out)
   );
endmodule

// File: rtl/mpas_quad_sum_chk.sv
module mpas_quad_sum_chk #(
   parameter int A_W         = 9,
   parameter int B_W         = 9,
   parameter bit IN_REG      = 1'b1,
   parameter bit OUT_REG     = 1'b1,
   parameter int IN_CE_SEL   = 0,
   parameter int IN_RST_SEL  = 0,
   parameter int OUT_CE_SEL  = 0,
   parameter int OUT_RST_SEL = 0
) (
   input logic                 clk,
   input logic [3:0]           ce,
   input logic [3:0]           rst,
   input logic                 a_shift,
   input logic                 b_shift,
   input logic [A_W-1:0]       a_shift_out,
   input logic [B_W-1:0]       b_shift_out,
   input logic [A_W-1:0]       a_lane2,
   input logic [B_W-1:0]       b_lane2,
   input logic [A_W+B_W+1:0]   sum_out
);
   logic started   = 1'b0;
   logic primed_in = 1'b0;
   logic primed_o  = 1'b0;

   always_ff @(posedge clk) begin
      started <= 1'b1;
      if (rst[IN_RST_SEL])  primed_in <= 1'b1;
      if (rst[OUT_RST_SEL]) primed_o  <= 1'b1;
   end

   generate
      if (IN_REG) begin : g_in_chk
         // R5: a shift capture moves lane 2 into lane 3
         assert_a_chain_R5: assert property (@(posedge clk) disable iff (!primed_in)
            (ce[IN_CE_SEL] && !rst[IN_RST_SEL] && a_shift) |=> (a_shift_out == $past(a_lane2)));
         // R6: same for the B chain
         assert_b_chain_R6: assert property (@(posedge clk) disable iff (!primed_in)
            (ce[IN_CE_SEL] && !rst[IN_RST_SEL] && b_shift) |=> (b_shift_out == $past(b_lane2)));
         // R8: input stage reset clears the operand registers
         assert_in_clear_R8: assert property (@(posedge clk) disable iff (!started)
            rst[IN_RST_SEL] |=> (a_shift_out == '0 && b_shift_out == '0));
         // R7: input stage hold keeps the chain outputs
         assert_in_hold_R7: assert property (@(posedge clk) disable iff (!primed_in)
            (!ce[IN_CE_SEL] && !rst[IN_RST_SEL]) |=> ($stable(a_shift_out) && $stable(b_shift_out)));
      end
      if (OUT_REG) begin : g_out_chk
         // R8: output stage reset clears the sum
         assert_out_clear_R8: assert property (@(posedge clk) disable iff (!started)
            rst[OUT_RST_SEL] |=> (sum_out == '0));
         // R7: output stage hold keeps the sum
         assert_out_hold_R7: assert property (@(posedge clk) disable iff (!primed_o)
            (!ce[OUT_CE_SEL] && !rst[OUT_RST_SEL]) |=> $stable(sum_out));
      end
   endgenerate
endmodule

bind mpas_quad_sum mpas_quad_sum_chk #(
   .A_W(A_W), .B_W(B_W), .IN_REG(IN_REG), .OUT_REG(OUT_REG),
   .IN_CE_SEL(IN_CE_SEL), .IN_RST_SEL(IN_RST_SEL),
   .OUT_CE_SEL(OUT_CE_SEL), .OUT_RST_SEL(OUT_RST_SEL)
) u_chk (
   .clk(clk), .ce(ce), .rst(rst), .a_shift(a_shift), .b_shift(b_shift),
   .a_shift_out(a_shift_out), .b_shift_out(b_shift_out),
   .a_lane2(a_q[2*A_W +: A_W]), .b_lane2(b_q[2*B_W +: B_W]),
   .sum_out(sum_out)
);

// File: tb/mpas_quad_sum_bench.sv
module mpas_quad_sum_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 9;
   localparam int BW = 9;
   localparam int SW = AW + BW + 2;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [3:0]      ce = 4'hF, rst = 4'hF;
   logic            sgn = 1'b0, add0 = 1'b1, add1 = 1'b1, a_sh = 1'b0, b_sh = 1'b0;
   logic [4*AW-1:0] a_in = '0;
   logic [4*BW-1:0] b_in = '0;
   logic [AW-1:0]   a_sin = '0;
   logic [BW-1:0]   b_sin = '0;

   logic [SW-1:0] sum_r, sum_c;
   logic [AW-1:0] aso_r, aso_c;
   logic [BW-1:0] bso_r, bso_c;

   // Registered build: input on ce0/rst0, pipeline on ce1/rst1, output on ce2/rst3
   mpas_quad_sum #(.A_W(AW), .B_W(BW), .IN_REG(1), .PIPE_REG(1), .OUT_REG(1),
      .IN_CE_SEL(0), .IN_RST_SEL(0), .PIPE_CE_SEL(1), .PIPE_RST_SEL(1),
      .OUT_CE_SEL(2), .OUT_RST_SEL(3)) u_mpas_quad_sum (
      .clk(clk), .ce(ce), .rst(rst), .signed_mode(sgn), .pair0_add(add0), .pair1_add(add1),
      .a_in(a_in), .b_in(b_in), .a_shift(a_sh), .b_shift(b_sh),
      .a_shift_in(a_sin), .b_shift_in(b_sin),
      .a_shift_out(aso_r), .b_shift_out(bso_r), .sum_out(sum_r));

   // Fully bypassed build
   mpas_quad_sum #(.A_W(AW), .B_W(BW), .IN_REG(0), .PIPE_REG(0), .OUT_REG(0)) u_mpas_quad_sum_comb (
      .clk(clk), .ce(ce), .rst(rst), .signed_mode(sgn), .pair0_add(add0), .pair1_add(add1),
      .a_in(a_in), .b_in(b_in), .a_shift(a_sh), .b_shift(b_sh),
      .a_shift_in(a_sin), .b_shift_in(b_sin),
      .a_shift_out(aso_c), .b_shift_out(bso_c), .sum_out(sum_c));

   int    n_chk = 0, n_fail = 0;
   bit    checking = 1'b0;
   string cur_req = "R8";

   function automatic longint val(input logic [15:0] x, input int w, input logic s);
      longint v = longint'(x & ((16'd1 << w) - 16'd1));
      if (s && v >= (longint'(1) << (w-1))) v = v - (longint'(1) << w);
      return v;
   endfunction

   function automatic logic [SW-1:0] combine(input longint p0, p1, p2, p3, input logic ad0, ad1);
      longint t;
      t = (ad0 ? p0 + p1 : p0 - p1) + (ad1 ? p2 + p3 : p2 - p3);
      return t[SW-1:0];
   endfunction

   // Behavioural reference model of the registered build
   logic [AW-1:0] ma [4];
   logic [BW-1:0] mb [4];
   logic          ms = 1'b0, m0 = 1'b0, m1 = 1'b0, pa0 = 1'b0, pa1 = 1'b0;
   longint        pp [4];
   logic [SW-1:0] os = '0;

   initial for (int i = 0; i < 4; i++) begin ma[i] = '0; mb[i] = '0; pp[i] = 0; end

   always @(posedge clk) begin
      if (rst[0]) begin
         for (int i = 0; i < 4; i++) begin ma[i] <= '0; mb[i] <= '0; end
         ms <= 1'b0; m0 <= 1'b0; m1 <= 1'b0;
      end else if (ce[0]) begin
         for (int i = 0; i < 4; i++) begin
            ma[i] <= a_sh ? ((i == 0) ? a_sin : ma[i-1]) : a_in[i*AW +: AW];
            mb[i] <= b_sh ? ((i == 0) ? b_sin : mb[i-1]) : b_in[i*BW +: BW];
         end
         ms <= sgn; m0 <= add0; m1 <= add1;
      end
      if (rst[1]) begin
         for (int i = 0; i < 4; i++) pp[i] <= 0;
         pa0 <= 1'b0; pa1 <= 1'b0;
      end else if (ce[1]) begin
         for (int i = 0; i < 4; i++) pp[i] <= val(16'(ma[i]), AW, ms) * val(16'(mb[i]), BW, ms);
         pa0 <= m0; pa1 <= m1;
      end
      if (rst[3])      os <= '0;
      else if (ce[2])  os <= combine(pp[0], pp[1], pp[2], pp[3], pa0, pa1);
   end

   task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // Compare every cycle at the falling edge
   always @(negedge clk) begin
      if (checking) begin
         longint        cp [4];
         logic [AW-1:0] la;
         logic [BW-1:0] lb;
         check(cur_req, "sum", 64'(sum_r), 64'(os));
         check(cur_req, "a_shift_out", 64'(aso_r), 64'(ma[3]));
         check(cur_req, "b_shift_out", 64'(bso_r), 64'(mb[3]));
         for (int i = 0; i < 4; i++) begin
            la = a_sh ? a_sin : a_in[i*AW +: AW];
            lb = b_sh ? b_sin : b_in[i*BW +: BW];
            cp[i] = val(16'(la), AW, sgn) * val(16'(lb), BW, sgn);
         end
         check("R10", "comb sum", 64'(sum_c), 64'(combine(cp[0], cp[1], cp[2], cp[3], add0, add1)));
         check("R10", "comb a_shift_out", 64'(aso_c), 64'(a_sh ? a_sin : a_in[3*AW +: AW]));
         check("R10", "comb b_shift_out", 64'(bso_c), 64'(b_sh ? b_sin : b_in[3*BW +: BW]));
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic rand_ops();
      a_in  = {$urandom, $urandom};
      b_in  = {$urandom, $urandom};
      a_sin = AW'($urandom);
      b_sin = BW'($urandom);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // Reset all sources
      repeat (3) step();
      checking = 1'b1;
      cur_req = "R8";
      repeat (2) step();
      check("R8", "reset sum", 64'(sum_r), 64'd0);
      rst = 4'h0;

      // R1: single impulse, result due three edges later
      cur_req = "R1";
      a_in = {9'd4, 9'd3, 9'd2, 9'd1};
      b_in = {9'd8, 9'd7, 9'd6, 9'd5};
      step();
      a_in = '0; b_in = '0;
      step(); step();
      check("R1", "impulse sum at third edge", 64'(sum_r), 64'(5 + 12 + 21 + 32));
      repeat (3) step();

      // R2: unsigned, both pairs adding
      cur_req = "R2"; sgn = 1'b0; add0 = 1'b1; add1 = 1'b1;
      repeat (40) begin rand_ops(); step(); end
      a_in = '1; b_in = '1;
      repeat (4) step();

      // R3: signed, with extreme operands
      cur_req = "R3"; sgn = 1'b1;
      repeat (40) begin rand_ops(); step(); end
      a_in = {4{9'h100}}; b_in = {4{9'h100}}; repeat (4) step();
      a_in = {4{9'h100}}; b_in = {4{9'h0FF}}; repeat (4) step();

      // R4: direction bits and mode changing every cycle
      cur_req = "R4";
      repeat (60) begin
         rand_ops(); sgn = 1'($urandom); add0 = 1'($urandom); add1 = 1'($urandom); step();
      end
      sgn = 1'b0; add0 = 1'b0; add1 = 1'b0;
      a_in = {9'h1FF, 9'd0, 9'h1FF, 9'd0}; b_in = '1; repeat (4) step();

      // R5: A chain shifting
      cur_req = "R5"; a_sh = 1'b1;
      repeat (12) begin rand_ops(); step(); end
      a_sh = 1'b0;
      // R6: B chain shifting
      cur_req = "R6"; b_sh = 1'b1;
      repeat (12) begin rand_ops(); step(); end
      b_sh = 1'b0;

      // R7: stage enables dropping at random
      cur_req = "R7";
      repeat (40) begin
         rand_ops(); ce = {1'b1, 3'($urandom)}; a_sh = 1'($urandom); step();
      end
      ce = 4'hF; a_sh = 1'b0;

      // R8: reset pulses on the used sources, including against a low enable
      cur_req = "R8";
      repeat (40) begin
         rand_ops(); sgn = 1'($urandom);
         rst = {1'(($urandom % 5) == 0), 1'b0, 1'(($urandom % 5) == 0), 1'(($urandom % 5) == 0)};
         ce  = {1'b1, 3'($urandom | 32'd6)};
         step();
      end
      rst = 4'h0; ce = 4'hF;

      // R9: sources no stage selects
      cur_req = "R9";
      repeat (30) begin
         rand_ops(); ce = {1'($urandom), 3'b111}; rst = {1'b0, 1'($urandom), 2'b00}; step();
      end
      ce = 4'hF; rst = 4'h0;
      repeat (4) step();

      checking = 1'b0;
      finish_run();
   end
endmodule